// File: doc/BRIEF.md
# Configurable SPI Master Shifter

This block is the bit engine of an SPI master. It moves one character per transfer between a single-entry transmit holding register and a single-entry receive buffer. A character is 8 or 9 bits long. SCK comes from a divider of the reference clock. Clock polarity, clock phase and bit order are static configuration inputs that the surrounding register file drives.

A transfer starts in one of two ways. The first is a word presented on the transmit strobe. The second is a read request with no transmit word pending, in which case a programmable filler word is shifted out. If a second word is loaded while a character is still in flight, the next character follows without an extra idle half period. A full receive buffer that receives a new character raises a sticky overflow flag. The flag rises either at once or only when the stale character is read out, as a mode input selects.

Top module: `spi_master_core`

## Requirements
- R1: `chsize` = 0 gives 8-bit characters: 16 SCK edges, `tx_data[8]` ignored and `rx_data[8]` read as 0. `chsize` = 1 gives 9-bit characters: 18 SCK edges. No SCK edge follows the last one of a transfer.
- R2: `lsb_first` = 0 moves the most significant bit first on both MOSI and MISO. `lsb_first` = 1 moves the least significant bit first.
- R3: Outside a transfer SCK rests at `cpol`: low for 0, high for 1.
- R4: With `cpha` = 0 the first bit is on MOSI before the first SCK edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With `cpha` = 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R5: Successive SCK edges within a transfer are `baud`+1 clock cycles apart, so the SCK period is 2×(`baud`+1) cycles.
- R6: A `rd_req` pulse with the transmit holding register empty starts a transfer that shifts out the filler word. The filler resets to 0x1FF and is loaded from `dummy_val` when `dummy_wr` is high.
- R7: `tx_ready` is high exactly when the holding register is empty. A word loaded during a transfer starts next, with its first SCK edge `baud`+1 cycles after the last edge of the previous character.
- R8: `done` is a one-cycle pulse on the clock edge of each character's last SCK edge. `rx_valid` rises on that same edge.
- R9: A received character stays in `rx_data` with `rx_valid` high until a cycle with `rx_ready` high. If that cycle is also the completion cycle, the new character is stored and no overflow occurs.
- R10: With `ovf_mode` = 1, a character completing into a full buffer sets `ovf` on the same edge as `done`. The new character is dropped.
- R11: With `ovf_mode` = 0, the lost character is remembered and `ovf` is set on the edge that pops the older buffered character.
- R12: `ovf` stays set until a cycle with `ovf_clr` high. A new overflow in that same cycle wins.
- R13: With `rx_en` = 0 the received bits are discarded. Neither `rx_valid` nor `ovf` rises.
- R14: With `en` = 0 no transfer starts and SCK does not toggle. A loaded word is held and starts once `en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low aborts and idles |
| rx_en | input | 1 | Keep received characters |
| chsize | input | 1 | 0: 8-bit, 1: 9-bit characters |
| baud | input | BW | Half-period divider value |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample leading edge, 1: sample trailing edge |
| lsb_first | input | 1 | 1: least significant bit first |
| ovf_mode | input | 1 | 1: immediate overflow, 0: in-stream overflow |
| dummy_wr | input | 1 | Load the filler word |
| dummy_val | input | DW | New filler word |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | DW | Transmit word |
| tx_ready | output | 1 | Holding register empty |
| rd_req | input | 1 | Request a receive-only transfer |
| rx_valid | output | 1 | Receive buffer holds a character |
| rx_ready | input | 1 | Consumer pops the receive buffer |
| rx_data | output | DW | Received character |
| ovf_clr | input | 1 | Clear the overflow flag |
| ovf | output | 1 | Sticky receive overflow |
| done | output | 1 | Character complete pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two events can land in the same cycle: a character completing into an occupied receive buffer, and the consumer popping that buffer. The bench raises `rx_ready` for exactly the cycle before the final SCK edge of the second of two back-to-back reads. It does this by counting cycles since the previous SCK edge against `baud`. It then checks that the newer character sits in the buffer and that `ovf` stays low, with immediate overflow mode selected so that a wrong ordering would show at once. Overflow timing is also compared in both modes against the `done` pulse and the later pop.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef struct packed {
        logic wide;
        logic cpol;
        logic cpha;
        logic lsb;
    } spim_mode_t;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [BW-1:0] div,
    output logic          tick
);
    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  spim_mode_t    mode,
    input  logic          avail,
    input  logic [DW-1:0] word_in,
    input  logic          miso,
    output logic          busy,
    output logic          take,
    output logic          fin,
    output logic [DW-1:0] rx_word,
    output logic          sck,
    output logic          mosi
);
    localparam int IW = $clog2(DW + 1);
    localparam int KW = IW + 1;

    typedef struct packed {
        logic          busy;
        logic          ph;
        logic [KW-1:0] k;
        logic [IW-1:0] idx;
        logic [DW-1:0] txw;
        logic [DW-1:0] rxw;
    } sh_t;

    sh_t s_d, s_q;
    logic [IW-1:0] nb, pos;
    logic [KW-1:0] last_k;
    logic          samp;
    logic [DW-1:0] smp_word;

    always_comb begin
        nb     = mode.wide ? IW'(DW) : IW'(DW - 1);
        last_k = {nb, 1'b0} - KW'(1);
        pos    = mode.lsb ? s_q.idx : (nb - IW'(1) - s_q.idx);
        samp   = (s_q.k[0] == mode.cpha);
        fin    = s_q.busy && tick && (s_q.k == last_k);
        take   = en && avail && (!s_q.busy || fin);

        smp_word = s_q.rxw;
        if (s_q.busy && tick && samp) smp_word[pos] = miso;
        rx_word = smp_word;

        s_d = s_q;
        if (s_q.busy && tick) begin
            s_d.ph  = ~s_q.ph;
            s_d.k   = s_q.k + KW'(1);
            s_d.rxw = smp_word;
            if (!samp && (s_q.k != '0)) s_d.idx = s_q.idx + IW'(1);
            if (fin) begin
                s_d.busy = 1'b0;
                s_d.ph   = 1'b0;
            end
        end
        if (take) begin
            s_d.busy = 1'b1;
            s_d.ph   = 1'b0;
            s_d.k    = '0;
            s_d.idx  = '0;
            s_d.txw  = word_in;
            s_d.rxw  = '0;
        end
        if (!en) begin
            s_d.busy = 1'b0;
            s_d.ph   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign sck  = mode.cpol ^ s_q.ph;
    assign mosi = s_q.busy & s_q.txw[pos];
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
    import spim_pkg::*;
#(
    parameter int DW = 9,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rx_en,
    input  logic          chsize,
    input  logic [BW-1:0] baud,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          lsb_first,
    input  logic          ovf_mode,
    input  logic          dummy_wr,
    input  logic [DW-1:0] dummy_val,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_ready,
    input  logic          rd_req,
    output logic          rx_valid,
    input  logic          rx_ready,
    output logic [DW-1:0] rx_data,
    input  logic          ovf_clr,
    output logic          ovf,
    output logic          done,
    output logic          sck,
    output logic          mosi,
    input  logic          miso
);
    typedef struct packed {
        logic          txv;
        logic [DW-1:0] txw;
        logic          rdp;
        logic [DW-1:0] dum;
        logic          rxv;
        logic [DW-1:0] rxw;
        logic          ovf;
        logic          ovp;
        logic          done;
    } core_t;

    core_t         c_d, c_q;
    spim_mode_t    mode;
    logic          tick, sh_busy, sh_take, sh_fin, avail, pop;
    logic [DW-1:0] start_word, sh_rx;

    assign mode       = '{wide: chsize, cpol: cpol, cpha: cpha, lsb: lsb_first};
    assign avail      = c_q.txv || c_q.rdp;
    assign start_word = c_q.txv ? c_q.txw : c_q.dum;

    spim_baud #(.BW(BW)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(sh_busy), .div(baud), .tick(tick)
    );

    spim_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .mode(mode),
        .avail(avail), .word_in(start_word), .miso(miso),
        .busy(sh_busy), .take(sh_take), .fin(sh_fin), .rx_word(sh_rx),
        .sck(sck), .mosi(mosi)
    );

    always_comb begin
        pop    = c_q.rxv && rx_ready;
        c_d    = c_q;
        c_d.done = sh_fin;
        if (sh_take) begin
            if (c_q.txv) c_d.txv = 1'b0;
            else         c_d.rdp = 1'b0;
        end
        if (tx_valid && !c_q.txv) begin
            c_d.txv = 1'b1;
            c_d.txw = tx_data;
        end
        if (rd_req)   c_d.rdp = 1'b1;
        if (dummy_wr) c_d.dum = dummy_val;
        if (ovf_clr)  c_d.ovf = 1'b0;
        if (pop) begin
            c_d.rxv = 1'b0;
            if (c_q.ovp) begin
                c_d.ovf = 1'b1;
                c_d.ovp = 1'b0;
            end
        end
        if (sh_fin && rx_en) begin
            if (!c_q.rxv || pop) begin
                c_d.rxv = 1'b1;
                c_d.rxw = sh_rx;
            end else if (ovf_mode) begin
                c_d.ovf = 1'b1;
            end else begin
                c_d.ovp = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.dum <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign tx_ready = !c_q.txv;
    assign rx_valid = c_q.rxv;
    assign rx_data  = c_q.rxw;
    assign ovf      = c_q.ovf;
    assign done     = c_q.done;
endmodule

// File: rtl/spim_chk.sv
module spim_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic fin,
    input logic cpol,
    input logic sck,
    input logic rx_en,
    input logic rx_valid,
    input logic rx_ready,
    input logic ovf,
    input logic ovf_clr,
    input logic done,
    input logic tx_valid,
    input logic tx_ready
);
    p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |=> (sck == cpol));

    p_edge_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cpol) && !$stable(sck)) |-> $past(busy));

    p_txhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    p_ovf_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !fin && !(rx_valid && rx_ready)) |=> !ovf);

    p_rxen_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rx_valid) |=> !rx_valid);
endmodule

bind spi_master_core spim_chk u_spim_chk (
    .clk(clk), .rst_n(rst_n), .busy(sh_busy), .fin(sh_fin), .cpol(cpol),
    .sck(sck), .rx_en(rx_en), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .ovf(ovf), .ovf_clr(ovf_clr), .done(done), .tx_valid(tx_valid),
    .tx_ready(tx_ready)
);

// File: tb/tb_spi_master_core.sv
module tb_spi_master_core;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       wide;
        logic       cpol;
        logic       cpha;
        logic       lsb;
        logic [7:0] baud;
        logic [8:0] txw;
        logic [8:0] srw;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 9'h0A5, 9'h03C},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'd0, 9'h0C3, 9'h081},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd1, 9'h1F0, 9'h155},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd3, 9'h1A5, 9'h14B},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'd1, 9'h101, 9'h0FE},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd0, 9'h0B6, 9'h1C9}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b1, rx_en = 1'b1, chsize = 1'b0, cpol = 1'b0, cpha = 1'b0;
    logic lsb_first = 1'b0, ovf_mode = 1'b1, dummy_wr = 1'b0;
    logic [7:0] baud = 8'd0;
    logic [8:0] dummy_val = '0, tx_data = '0, rx_data;
    logic tx_valid = 1'b0, rd_req = 1'b0, rx_ready = 1'b0, ovf_clr = 1'b0;
    logic miso = 1'b0;
    logic tx_ready, rx_valid, ovf, done, sck, mosi;

    int n_chk = 0, n_fail = 0;
    logic [8:0] cap [2];
    logic [8:0] rxg [2];
    logic rxv_at, ovf_at;
    int gaps_bad, ndone, done_bad, extra;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_master_core dut (
        .clk(clk), .rst_n(rst_n), .en(en), .rx_en(rx_en), .chsize(chsize),
        .baud(baud), .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first),
        .ovf_mode(ovf_mode), .dummy_wr(dummy_wr), .dummy_val(dummy_val),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rd_req(rd_req), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .ovf_clr(ovf_clr), .ovf(ovf), .done(done),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int bpos(input vec_t v, input int nb, input int i);
        return v.lsb ? i : nb - 1 - i;
    endfunction

    task automatic pop_rx();
        @(negedge clk) rx_ready = 1'b1;
        @(negedge clk) rx_ready = 1'b0;
    endtask

    task automatic clear_ovf();
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
    endtask

    task automatic xfer(input vec_t v, input bit use_rd, input bit two,
                        input logic [8:0] tx2, input bit pop_end);
        int nb, total, e, gap, eb, bi, w, guard;
        logic ps, pm;
        nb = v.wide ? 9 : 8;
        total = (two ? 2 : 1) * 2 * nb;
        chsize = v.wide; cpol = v.cpol; cpha = v.cpha; lsb_first = v.lsb; baud = v.baud;
        cap[0] = '0; cap[1] = '0; rxg[0] = '0; rxg[1] = '0;
        gaps_bad = 0; ndone = 0; done_bad = 0; extra = 0; rxv_at = 1'b0; ovf_at = 1'b0;
        miso = v.srw[bpos(v, nb, 0)];
        @(negedge clk);
        chk("R3 idle SCK level", 32'(sck), 32'(v.cpol));
        if (use_rd) rd_req = 1'b1;
        else begin
            tx_valid = 1'b1;
            tx_data = v.txw;
        end
        @(negedge clk);
        rd_req = 1'b0; tx_valid = 1'b0;
        ps = sck; pm = mosi; e = 0; gap = 0; guard = 0;
        while (e < total && guard < 5000) begin
            @(negedge clk);
            tx_valid = 1'b0;
            gap++; guard++;
            if (sck !== ps) begin
                eb = e % (2 * nb); bi = eb / 2; w = e / (2 * nb);
                if (((eb % 2) == 0) == (v.cpha == 1'b0)) cap[w][bpos(v, nb, bi)] = pm;
                if (e > 0 && gap != int'(v.baud) + 1) gaps_bad++;
                if (v.cpha == 1'b0 && (eb % 2) == 1) miso = v.srw[bpos(v, nb, (bi + 1) % nb)];
                if (v.cpha == 1'b1 && (eb % 2) == 0) miso = v.srw[bpos(v, nb, bi)];
                if (eb == 2 * nb - 1) begin
                    if (done === 1'b1) ndone++;
                    rxg[w] = rx_data; rxv_at = rx_valid; ovf_at = ovf;
                end else if (done !== 1'b0) begin
                    done_bad++;
                end
                if (two && e == 0) begin
                    tx_valid = 1'b1;
                    tx_data = tx2;
                end
                gap = 0; e++;
            end
            ps = sck; pm = mosi;
            if (pop_end) rx_ready = (e == total - 1) && (gap == int'(v.baud));
        end
        rx_ready = 1'b0;
        repeat (int'(v.baud) + 4) begin
            @(negedge clk);
            if (sck !== ps) extra++;
            ps = sck;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        vec_t v;
        logic [8:0] m;
        int cnt;
        repeat (3) @(negedge clk);
        chk("R3 reset SCK", 32'(sck), 32'd0);
        chk("R7 reset tx_ready", 32'(tx_ready), 32'd1);
        chk("R9 reset rx_valid", 32'(rx_valid), 32'd0);
        chk("R12 reset ovf", 32'(ovf), 32'd0);
        chk("R8 reset done", 32'(done), 32'd0);
        chk("R4 reset mosi", 32'(mosi), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            m = v.wide ? 9'h1FF : 9'h0FF;
            xfer(v, 1'b0, 1'b0, '0, 1'b0);
            chk("R1 R2 R4 MOSI word", 32'(cap[0]), 32'(v.txw & m));
            chk("R1 R2 R4 MISO word", 32'(rxg[0]), 32'(v.srw & m));
            chk("R5 edge spacing", 32'(gaps_bad), 32'd0);
            chk("R1 no extra edge", 32'(extra), 32'd0);
            chk("R8 done and rx_valid", 32'({ndone[3:0], done_bad[3:0], 3'b0, rxv_at}), 32'h101);
            chk("R3 idle after", 32'(sck), 32'(v.cpol));
            pop_rx();
        end

        v = '{1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 9'h000, 9'h000};
        xfer(v, 1'b1, 1'b0, '0, 1'b0);
        chk("R6 reset filler", 32'(cap[0]), 32'h1FF);
        pop_rx();
        @(negedge clk) begin dummy_wr = 1'b1; dummy_val = 9'h0A5; end
        @(negedge clk) dummy_wr = 1'b0;
        xfer(v, 1'b1, 1'b0, '0, 1'b0);
        chk("R6 loaded filler", 32'(cap[0]), 32'h0A5);
        pop_rx();

        rx_en = 1'b0;
        v = '{1'b0, 1'b1, 1'b0, 1'b1, 8'd2, 9'h03C, 9'h0F0};
        xfer(v, 1'b0, 1'b1, 9'h0E1, 1'b0);
        chk("R7 back-to-back spacing", 32'(gaps_bad), 32'd0);
        chk("R7 first word", 32'(cap[0]), 32'h03C);
        chk("R7 second word", 32'(cap[1]), 32'h0E1);
        chk("R8 two done pulses", 32'(ndone), 32'd2);
        chk("R13 no rx_valid", 32'(rx_valid), 32'd0);
        chk("R13 no ovf", 32'(ovf), 32'd0);

        @(negedge clk) en = 1'b0;
        @(negedge clk) begin tx_valid = 1'b1; tx_data = 9'h055; end
        @(negedge clk) tx_valid = 1'b0;
        cnt = 0;
        begin
            logic ps;
            ps = sck;
            repeat (20) begin
                @(negedge clk);
                if (sck !== ps) cnt++;
                ps = sck;
            end
        end
        chk("R14 no SCK while disabled", 32'(cnt), 32'd0);
        chk("R14 word held", 32'(tx_ready), 32'd0);
        en = 1'b1;
        cnt = 0;
        for (int k = 0; k < 400 && cnt == 0; k++) begin
            @(negedge clk);
            if (done) cnt = 1;
        end
        chk("R14 starts after enable", 32'(cnt), 32'd1);
        repeat (4) @(negedge clk);

        rx_en = 1'b1; ovf_mode = 1'b1;
        v = '{1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 9'h011, 9'h05A};
        xfer(v, 1'b0, 1'b0, '0, 1'b0);
        v.srw = 9'h0A5;
        xfer(v, 1'b0, 1'b0, '0, 1'b0);
        chk("R10 immediate ovf with done", 32'(ovf_at), 32'd1);
        chk("R10 new char dropped", 32'(rx_data), 32'h05A);
        repeat (5) @(negedge clk);
        chk("R12 ovf sticky", 32'(ovf), 32'd1);
        chk("R9 rx_valid held", 32'(rx_valid), 32'd1);
        clear_ovf();
        chk("R12 ovf cleared", 32'(ovf), 32'd0);
        pop_rx();

        ovf_mode = 1'b0;
        v.srw = 9'h05A;
        xfer(v, 1'b0, 1'b0, '0, 1'b0);
        v.srw = 9'h0A5;
        xfer(v, 1'b0, 1'b0, '0, 1'b0);
        chk("R11 no ovf at done", 32'(ovf_at), 32'd0);
        chk("R11 no ovf before read", 32'(ovf), 32'd0);
        pop_rx();
        chk("R11 ovf on read", 32'(ovf), 32'd1);
        chk("R9 buffer emptied", 32'(rx_valid), 32'd0);
        clear_ovf();

        ovf_mode = 1'b1;
        v.srw = 9'h033;
        xfer(v, 1'b0, 1'b0, '0, 1'b0);
        v.srw = 9'h0CC;
        xfer(v, 1'b0, 1'b0, '0, 1'b1);
        chk("R9 coincident pop keeps new", 32'(rx_data), 32'h0CC);
        chk("R9 coincident pop valid", 32'(rx_valid), 32'd1);
        chk("R9 coincident pop no ovf", 32'(ovf), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule